// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits on the host side of a parallel flash bus. A client issues one of three jobs through a request/ready handshake: program one word, erase one sector, or erase the whole chip. The sequencer turns the job into the unlock and command write cycles the flash expects. Each write cycle is a single-cycle strobe on an abstract flash port. The sequencer then issues repeated reads until the flash reports that its internal operation has finished. It ends every job with a one-cycle `done` or `error` pulse.

Completion detection is chosen at compile time. In data-poll mode the sequencer watches bit 7 of the read word. In toggle mode it watches bit 6 across two reads in a row. The number of polling reads is bounded by a parameter. When that limit is reached, the sequencer writes a reset command and reports an error. After a program job completes, the sequencer reads the word back once more to confirm the contents.

The flash read port has one cycle of latency: `fl_rdata` must be valid in the cycle after `fl_re` is high.

Top module: `flash_seq`

## Requirements
- R1: After reset `req_ready` is 1. A valid opcode accepted (`req_valid` and `req_ready` both high at a clock edge) drives `req_ready` low from the next cycle. `req_ready` returns high in the same cycle as the `done` or `error` pulse.
- R2: Opcode 2'b00 (program) issues exactly four writes, one per cycle, in this order: 0x5555/0x00AA, 0x2AAA/0x0055, 0x5555/0x00A0, and finally the request address with the request data. Command bytes are sent with a zero upper byte.
- R3: Opcode 2'b10 (chip erase) issues six writes: 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x10.
- R4: Opcode 2'b01 (sector erase) issues the same first five writes as a chip erase. Its sixth write is 0x30 at the request address.
- R5: Every polling and verify read uses the request address, and reads never coincide with writes.
- R6: In data-poll mode, a program job stops polling on the first read whose bit 7 equals bit 7 of the written data.
- R7: In data-poll mode, an erase job stops polling on the first read with bit 7 set, and then pulses `done`.
- R8: In toggle mode, a job stops polling on the first read whose bit 6 equals bit 6 of the read just before it.
- R9: If POLL_LIMIT reads pass without completion, the sequencer issues one write of 0x00F0 at 0x5555. It then pulses `error` in the next cycle.
- R10: After program polling completes, exactly one more read is made at the target. If the whole word equals the written data, `done` pulses; otherwise `error` pulses, with no reset write.
- R11: `done` and `error` are single-cycle pulses and never high together.
- R12: Opcode 2'b11 is rejected with an `error` pulse in the cycle after acceptance, with no flash access, and `req_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Job request valid |
| req_ready | output | 1 | Sequencer idle and able to accept a job |
| req_op | input | 2 | Job code: 00 program, 01 sector erase, 10 chip erase, 11 reserved |
| req_addr | input | AW | Target word address (sector address for erases, poll address for chip erase) |
| req_data | input | DW | Word to program |
| fl_we | output | 1 | One-cycle flash write strobe |
| fl_re | output | 1 | One-cycle flash read strobe |
| fl_addr | output | AW | Flash address |
| fl_wdata | output | DW | Flash write data |
| fl_rdata | input | DW | Flash read data, valid the cycle after `fl_re` |
| done | output | 1 | Job finished successfully (pulse) |
| error | output | 1 | Job failed: timeout, verify mismatch or reserved code (pulse) |

## Verification
A wrong step counter or a wrong opcode latch shows up at the write port as a misplaced address or command byte, within the first six cycles after acceptance. The scoreboard compares every write against the expected list in order, so such a fault is caught at the first bad write. A fault in completion detection or in the poll counter shows up as a wrong number of reads before the final pulse, or as the wrong pulse. The exact read count is checked for every data-poll job, so an off-by-one is exposed by the end of that job. A held address that drifts is flagged on the first read that uses a different address.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'b00,
        OP_SECT = 2'b01,
        OP_CHIP = 2'b10,
        OP_RSVD = 2'b11
    } job_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WRITE,
        S_POLL_RD,
        S_POLL_WT,
        S_VER_RD,
        S_VER_WT,
        S_ABORT
    } state_e;

    localparam logic [15:0] ADDR_KEY_A = 16'h5555;
    localparam logic [15:0] ADDR_KEY_B = 16'h2AAA;

    localparam logic [7:0] BYTE_KEY_A   = 8'hAA;
    localparam logic [7:0] BYTE_KEY_B   = 8'h55;
    localparam logic [7:0] BYTE_PROG    = 8'hA0;
    localparam logic [7:0] BYTE_ERASE   = 8'h80;
    localparam logic [7:0] BYTE_CHIP    = 8'h10;
    localparam logic [7:0] BYTE_SECTOR  = 8'h30;
    localparam logic [7:0] BYTE_RESET   = 8'hF0;

    // index of the final write cycle for a job
    function automatic logic [2:0] last_step(job_e op);
        return (op == OP_PROG) ? 3'd3 : 3'd5;
    endfunction

endpackage

// File: rtl/flash_seq_cmdgen.sv
module flash_seq_cmdgen
    import flash_seq_pkg::*;
#(
    parameter int AW = 18,
    parameter int DW = 16
) (
    input  job_e             op,
    input  logic [2:0]       step,
    input  logic [AW-1:0]    tgt_addr,
    input  logic [DW-1:0]    tgt_data,
    output logic [AW-1:0]    wr_addr,
    output logic [DW-1:0]    wr_data
);
    localparam logic [AW-1:0] KA = AW'(ADDR_KEY_A);
    localparam logic [AW-1:0] KB = AW'(ADDR_KEY_B);

    function automatic logic [DW-1:0] cmd(logic [7:0] b);
        return DW'(b);
    endfunction

    always_comb begin
        wr_addr = KA;
        wr_data = cmd(BYTE_KEY_A);
        unique case (step)
            3'd0: begin wr_addr = KA; wr_data = cmd(BYTE_KEY_A); end
            3'd1: begin wr_addr = KB; wr_data = cmd(BYTE_KEY_B); end
            3'd2: begin
                wr_addr = KA;
                wr_data = (op == OP_PROG) ? cmd(BYTE_PROG) : cmd(BYTE_ERASE);
            end
            3'd3: begin
                if (op == OP_PROG) begin
                    wr_addr = tgt_addr;
                    wr_data = tgt_data;
                end else begin
                    wr_addr = KA;
                    wr_data = cmd(BYTE_KEY_A);
                end
            end
            3'd4: begin wr_addr = KB; wr_data = cmd(BYTE_KEY_B); end
            default: begin
                if (op == OP_CHIP) begin
                    wr_addr = KA;
                    wr_data = cmd(BYTE_CHIP);
                end else begin
                    wr_addr = tgt_addr;
                    wr_data = cmd(BYTE_SECTOR);
                end
            end
        endcase
    end
endmodule

// File: rtl/flash_seq_polleval.sv
module flash_seq_polleval #(
    parameter bit TOGGLE_MODE = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic sample,
    input  logic is_prog,
    input  logic exp_b7,
    input  logic rd_b7,
    input  logic rd_b6,
    output logic complete
);
    logic prev_b6_q;
    logic have_prev_q;
    logic tog_done;
    logic dat_done;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            prev_b6_q   <= 1'b0;
            have_prev_q <= 1'b0;
        end else if (sample) begin
            prev_b6_q   <= rd_b6;
            have_prev_q <= 1'b1;
        end
    end

    always_comb begin
        tog_done = have_prev_q && (prev_b6_q == rd_b6);
        dat_done = is_prog ? (rd_b7 == exp_b7) : rd_b7;
        complete = TOGGLE_MODE ? tog_done : dat_done;
    end
endmodule

// File: rtl/flash_seq.sv
module flash_seq
    import flash_seq_pkg::*;
#(
    parameter int AW          = 18,
    parameter int DW          = 16,
    parameter int POLL_LIMIT  = 4096,
    parameter bit TOGGLE_MODE = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    output logic          fl_we,
    output logic          fl_re,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_wdata,
    input  logic [DW-1:0] fl_rdata,
    output logic          done,
    output logic          error
);
    localparam int CW = $clog2(POLL_LIMIT + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(POLL_LIMIT - 1);

    state_e        state_q;
    job_e          op_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic [2:0]    step_q;
    logic [CW-1:0] cnt_q;
    logic          done_q;
    logic          err_q;

    logic [AW-1:0] gen_addr;
    logic [DW-1:0] gen_data;
    logic          poll_ok;

    flash_seq_cmdgen #(.AW(AW), .DW(DW)) cmdgen_i (
        .op       (op_q),
        .step     (step_q),
        .tgt_addr (addr_q),
        .tgt_data (data_q),
        .wr_addr  (gen_addr),
        .wr_data  (gen_data)
    );

    flash_seq_polleval #(.TOGGLE_MODE(TOGGLE_MODE)) polleval_i (
        .clk      (clk),
        .rst      (rst),
        .clear    (state_q == S_WRITE),
        .sample   (state_q == S_POLL_WT),
        .is_prog  (op_q == OP_PROG),
        .exp_b7   (data_q[7]),
        .rd_b7    (fl_rdata[7]),
        .rd_b6    (fl_rdata[6]),
        .complete (poll_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            op_q    <= OP_PROG;
            addr_q  <= '0;
            data_q  <= '0;
            step_q  <= '0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (req_valid) begin
                        if (job_e'(req_op) == OP_RSVD) begin
                            err_q <= 1'b1;
                        end else begin
                            op_q    <= job_e'(req_op);
                            addr_q  <= req_addr;
                            data_q  <= req_data;
                            step_q  <= '0;
                            cnt_q   <= '0;
                            state_q <= S_WRITE;
                        end
                    end
                end
                S_WRITE: begin
                    if (step_q == last_step(op_q)) begin
                        step_q  <= '0;
                        state_q <= S_POLL_RD;
                    end else begin
                        step_q <= step_q + 3'd1;
                    end
                end
                S_POLL_RD: state_q <= S_POLL_WT;
                S_POLL_WT: begin
                    if (poll_ok) begin
                        if (op_q == OP_PROG) begin
                            state_q <= S_VER_RD;
                        end else begin
                            done_q  <= 1'b1;
                            state_q <= S_IDLE;
                        end
                    end else if (cnt_q == CNT_LAST) begin
                        state_q <= S_ABORT;
                    end else begin
                        cnt_q   <= cnt_q + 1'b1;
                        state_q <= S_POLL_RD;
                    end
                end
                S_VER_RD: state_q <= S_VER_WT;
                S_VER_WT: begin
                    if (fl_rdata == data_q) done_q <= 1'b1;
                    else                    err_q  <= 1'b1;
                    state_q <= S_IDLE;
                end
                S_ABORT: begin
                    err_q   <= 1'b1;
                    state_q <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready = (state_q == S_IDLE);
        fl_we     = (state_q == S_WRITE) || (state_q == S_ABORT);
        fl_re     = (state_q == S_POLL_RD) || (state_q == S_VER_RD);
        done      = done_q;
        error     = err_q;
        if (state_q == S_WRITE) begin
            fl_addr  = gen_addr;
            fl_wdata = gen_data;
        end else if (state_q == S_ABORT) begin
            fl_addr  = AW'(ADDR_KEY_A);
            fl_wdata = DW'(BYTE_RESET);
        end else begin
            fl_addr  = addr_q;
            fl_wdata = '0;
        end
    end
endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk #(
    parameter int AW = 18,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_ready,
    input logic [1:0]    req_op,
    input logic [AW-1:0] req_addr,
    input logic          fl_we,
    input logic          fl_re,
    input logic [AW-1:0] fl_addr,
    input logic [DW-1:0] fl_wdata,
    input logic          done,
    input logic          error
);
    logic [AW-1:0] held_addr;

    always_ff @(posedge clk) begin
        if (rst)                         held_addr <= '0;
        else if (req_valid && req_ready) held_addr <= req_addr;
    end

    // R1
    ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_op != 2'b11) |=> !req_ready);

    // R1
    ready_back_chk: assert property (@(posedge clk) disable iff (rst)
        (done || error) |-> req_ready);

    // R5
    poll_addr_chk: assert property (@(posedge clk) disable iff (rst)
        fl_re |-> (fl_addr == held_addr));

    // R5
    port_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(fl_we && fl_re));

    // R9
    abort_err_chk: assert property (@(posedge clk) disable iff (rst)
        (fl_we && fl_wdata[7:0] == 8'hF0) |=> error);

    // R11
    pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && error));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11
    err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        error |=> !error);
endmodule

bind flash_seq flash_seq_chk #(.AW(AW), .DW(DW)) chk_i (.*);

// File: tb/flash_seq_tb_top.sv
module flash_seq_tb_top;
    localparam int AW = 18;
    localparam int DW = 16;
    localparam int LIM = 16;

    typedef struct packed {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic          last;
    } wr_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic          req_valid = 1'b0;
    logic [1:0]    req_op    = 2'b00;
    logic [AW-1:0] req_addr  = '0;
    logic [DW-1:0] req_data  = '0;
    logic [DW-1:0] fl_rdata  = '0;
    int            lane      = 0;

    logic          rdy0, we0, re0, dn0, er0;
    logic          rdy1, we1, re1, dn1, er1;
    logic [AW-1:0] ad0, ad1;
    logic [DW-1:0] wd0, wd1;

    flash_seq #(.AW(AW), .DW(DW), .POLL_LIMIT(LIM), .TOGGLE_MODE(1'b0)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid && lane == 0), .req_ready(rdy0),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
        .fl_we(we0), .fl_re(re0), .fl_addr(ad0), .fl_wdata(wd0), .fl_rdata(fl_rdata),
        .done(dn0), .error(er0));

    flash_seq #(.AW(AW), .DW(DW), .POLL_LIMIT(LIM), .TOGGLE_MODE(1'b1)) dut_t (
        .clk(clk), .rst(rst), .req_valid(req_valid && lane == 1), .req_ready(rdy1),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
        .fl_we(we1), .fl_re(re1), .fl_addr(ad1), .fl_wdata(wd1), .fl_rdata(fl_rdata),
        .done(dn1), .error(er1));

    logic          m_we, m_re, m_dn, m_er, m_rdy;
    logic [AW-1:0] m_ad;
    logic [DW-1:0] m_wd;
    always_comb begin
        m_we  = lane == 1 ? we1  : we0;
        m_re  = lane == 1 ? re1  : re0;
        m_ad  = lane == 1 ? ad1  : ad0;
        m_wd  = lane == 1 ? wd1  : wd0;
        m_dn  = lane == 1 ? dn1  : dn0;
        m_er  = lane == 1 ? er1  : er0;
        m_rdy = lane == 1 ? rdy1 : rdy0;
    end

    // scoreboard and flash behaviour
    wr_t           exp_q[$];
    string         cur_tag = "R2";
    logic [15:0]   mem[int];
    int            cfg_busy = 0;
    int            cfg_kind = 0;   // 0 program, 1 sector, 2 chip
    int            busy_left = 0;
    int            busy_kind = -1;
    logic [AW-1:0] p_addr;
    logic [DW-1:0] p_data;
    logic          tog = 1'b0;
    int            reads = 0;
    logic [AW-1:0] poll_addr = '0;

    function automatic logic [15:0] rd_mem(int a);
        return mem.exists(a) ? mem[a] : 16'hFFFF;
    endfunction

    task automatic fail_msg(string tag, string what, longint act, longint exp);
        fails++;
        $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    endtask

    task automatic check(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) fail_msg(tag, what, act, exp);
    endtask

    task automatic apply_effect();
        if (busy_kind == 0) begin
            mem[int'(p_addr)] = rd_mem(int'(p_addr)) & p_data;
        end else if (busy_kind == 1) begin
            foreach (mem[k]) if ((k >> 13) == (int'(p_addr) >> 13)) mem[k] = 16'hFFFF;
        end else if (busy_kind == 2) begin
            mem.delete();
        end
        busy_kind = -1;
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (m_we) begin
                if (exp_q.size() == 0) begin
                    checks++;
                    fail_msg(cur_tag, "unexpected write addr", m_ad, 0);
                end else begin
                    wr_t e;
                    e = exp_q.pop_front();
                    check(cur_tag, "write addr", m_ad, e.a);
                    check(cur_tag, "write data", m_wd, e.d);
                    if (m_wd[7:0] == 8'hF0) begin
                        busy_left = 0;
                        busy_kind = -1;
                    end
                    if (e.last) begin
                        busy_kind = cfg_kind;
                        busy_left = cfg_busy;
                        p_addr    = (cfg_kind == 0) ? m_ad : req_addr;
                        p_data    = m_wd;
                        if (busy_left == 0) apply_effect();
                    end
                end
            end
            if (m_re) begin
                reads++;
                // R5 reads stay on the request address
                check("R5", "read addr", m_ad, poll_addr);
                if (busy_left > 0) begin
                    fl_rdata <= {8'h00, (busy_kind == 0) ? ~p_data[7] : 1'b0, tog, 6'h00};
                    tog = ~tog;
                    busy_left--;
                    if (busy_left == 0) apply_effect();
                end else begin
                    fl_rdata <= rd_mem(int'(m_ad));
                end
            end
        end
    end

    task automatic push_w(logic [AW-1:0] a, logic [7:0] b, logic last);
        wr_t e;
        e.a = a; e.d = {8'h00, b}; e.last = last;
        exp_q.push_back(e);
    endtask

    task automatic run_op(int ln, logic [1:0] op, logic [AW-1:0] a, logic [DW-1:0] d,
                          int busy, bit exp_done, int exp_reads, bit exp_f0, string tag);
        int  n;
        bit  ready_hi;
        wr_t e;
        lane = ln; cur_tag = tag; reads = 0; poll_addr = a;
        cfg_busy = busy;
        cfg_kind = (op == 2'b00) ? 0 : (op == 2'b01) ? 1 : 2;
        if (op != 2'b11) begin
            push_w(18'h05555, 8'hAA, 1'b0);
            push_w(18'h02AAA, 8'h55, 1'b0);
            if (op == 2'b00) begin
                push_w(18'h05555, 8'hA0, 1'b0);
                e.a = a; e.d = d; e.last = 1'b1;
                exp_q.push_back(e);
            end else begin
                push_w(18'h05555, 8'h80, 1'b0);
                push_w(18'h05555, 8'hAA, 1'b0);
                push_w(18'h02AAA, 8'h55, 1'b0);
                if (op == 2'b10) push_w(18'h05555, 8'h10, 1'b1);
                else             push_w(a, 8'h30, 1'b1);
            end
            if (exp_f0) push_w(18'h05555, 8'hF0, 1'b0);
        end
        @(negedge clk);
        req_op = op; req_addr = a; req_data = d; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (op == 2'b11) begin
            check("R12", "ready after reserved code", m_rdy, 1);
            check("R12", "error after reserved code", m_er, 1);
        end else begin
            check("R1", "ready after accept", m_rdy, 0);
        end
        n = 0; ready_hi = 1'b0;
        while (!(m_dn || m_er) && n < 3000) begin
            if (m_rdy) ready_hi = 1'b1;
            @(negedge clk);
            n++;
        end
        if (op != 2'b11) check("R1", "ready rose before end", ready_hi, 0);
        check(tag, "done", m_dn, exp_done);
        check(tag, "error", m_er, !exp_done);
        check("R1", "ready with end pulse", m_rdy, 1);
        check(tag, "writes left", exp_q.size(), 0);
        if (exp_reads >= 0) check(tag, "read count", reads, exp_reads);
        exp_q.delete();
        @(negedge clk);
        check("R11", "done pulse width", m_dn, 0);
        check("R11", "error pulse width", m_er, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1", "ready0 after reset", rdy0, 1);
        check("R1", "ready1 after reset", rdy1, 1);
        check("R1", "strobes idle", {we0, re0, we1, re1}, 0);
        check("R11", "pulses idle", {dn0, er0, dn1, er1}, 0);

        // R2 / R6 / R10 program, data poll, bit7 of data = 1
        run_op(0, 2'b00, 18'h00123, 16'hC3A5, 3, 1'b1, 5, 1'b0, "R6");
        // R2 program with bit7 = 0, done on first poll read
        run_op(0, 2'b00, 18'h05010, 16'h1234, 0, 1'b1, 2, 1'b0, "R2");
        // R4 / R7 sector erase
        run_op(0, 2'b01, 18'h05123, 16'h0000, 5, 1'b1, 6, 1'b0, "R4");
        check("R4", "sector contents erased", rd_mem(32'h05010), 16'hFFFF);
        // R3 / R7 chip erase
        mem[32'h00200] = 16'h0000;
        run_op(0, 2'b10, 18'h00200, 16'h0000, 2, 1'b1, 3, 1'b0, "R3");
        check("R7", "chip contents erased", rd_mem(32'h00200), 16'hFFFF);
        // R9 timeout with reset write
        run_op(0, 2'b00, 18'h3F000, 16'hA5A5, 100, 1'b0, LIM, 1'b1, "R9");
        // R10 verify mismatch: zeros cannot be programmed back to ones
        mem[32'h00100] = 16'h00FF;
        run_op(0, 2'b00, 18'h00100, 16'hFF00, 2, 1'b0, 4, 1'b0, "R10");
        // R12 reserved code
        run_op(0, 2'b11, 18'h00000, 16'h0000, 0, 1'b0, 0, 1'b0, "R12");
        // R8 toggle lane
        run_op(1, 2'b00, 18'h00400, 16'h5A5A, 4, 1'b1, -1, 1'b0, "R8");
        check("R8", "programmed word", rd_mem(32'h00400), 16'h5A5A);
        run_op(1, 2'b01, 18'h03001, 16'h0000, 3, 1'b1, -1, 1'b0, "R8");
        run_op(1, 2'b00, 18'h00777, 16'h0F0F, 100, 1'b0, LIM, 1'b1, "R9");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule